// File: doc/BRIEF.md
# SIMD Floating-Point minNum / maxNum Unit

This unit takes two 64-bit operand words and returns, per lane, the IEEE754-2008 minNum or maxNum of each lane pair. One result word leaves the unit per cycle, one clock after the operands are accepted. A wide vector operation is issued as two back-to-back words that carry the same lane settings.

A mode input picks between two ways of packing the word. Vector mode splits the word into two single-precision lanes or four half-precision lanes. Scalar mode works on a single half, single or double operand held in the low bits of the word. A quiet NaN that meets a number gives the number. A signalling NaN makes the lane produce a quiet NaN and raises the invalid-operation flag. Vector mode flushes denormal inputs to zero and always uses the default NaN. A size code with no meaning raises an undefined flag in place of a result.

Top module: `simd_fp_minmax`

## Requirements
- R1: When exactly one operand of a lane is a quiet NaN (exponent all ones, mantissa MSB 1) and the other is not a NaN, the lane result is the non-NaN operand and the lane does not raise invalid.
- R2: When exactly one operand of a lane is a signalling NaN (exponent all ones, mantissa nonzero with MSB 0), invalid_o is 1. The lane result is the default NaN in vector mode. In scalar mode it is that operand with its mantissa MSB set. Lanes that are not in use never raise invalid_o.
- R3: When both operands of a lane are NaN, the lane result is the default NaN: sign 0, exponent all ones, mantissa MSB 1 and all other bits 0 (0x7E00, 0x7FC00000, 0x7FF8000000000000). invalid_o is 1 only if one of the two is signalling.
- R4: op_min_i = 0 selects the maximum and op_min_i = 1 selects the minimum. For non-NaN operands, order follows sign and magnitude: any negative is below any positive, and of two negatives the one with the larger magnitude is the smaller.
- R5: When +0 is compared with -0, the minimum is -0 and the maximum is +0.
- R6: In vector mode (vec_i = 1), size_i = 00 gives two 32-bit lanes in bits 63:32 and 31:0. size_i = 01 gives four 16-bit lanes at bits 63:48, 47:32, 31:16 and 15:0. The lanes are independent. size_i = 10 or 11 is undefined (see R9).
- R7: In vector mode, a denormal input (exponent 0, mantissa nonzero) is treated as a zero of the same sign. In scalar mode, denormals are compared as they are.
- R8: In scalar mode (vec_i = 0), size_i = 01 works on bits 15:0 and returns bits 63:16 as zero. size_i = 10 works on bits 31:0 and returns bits 63:32 as zero. size_i = 11 works on all 64 bits as a double.
- R9: An undefined combination (scalar size_i = 00, or vector size_i = 1x) gives undef_o = 1, res_o = 0 and invalid_o = 0, whatever the operands are.
- R10: Operands taken with valid_i = 1 produce res_o, invalid_o and undef_o on the next clock edge, with valid_o = 1. Consecutive words are each processed in full. While valid_i = 0 the result outputs hold their values and valid_o returns to 0.
- R11: Reset (rst_ni low) clears valid_o, res_o, invalid_o and undef_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand word valid |
| vec_i | input | 1 | 1 = vector lanes, 0 = scalar |
| size_i | input | 2 | Lane / element size code |
| op_min_i | input | 1 | 0 = maximum, 1 = minimum |
| a_i | input | 64 | First operand word |
| b_i | input | 64 | Second operand word |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Result word |
| invalid_o | output | 1 | Invalid-operation flag |
| undef_o | output | 1 | Undefined size/mode combination |

## Verification
Two things can meet in the same cycle: the quiet-NaN rule, which returns the number, and signalling-NaN handling, which raises invalid and returns a NaN. This can happen across lanes of one vector word, or inside one lane when both operands are NaN. The bench sends vector words in which one lane holds a quiet NaN and a neighbouring lane holds a signalling NaN. It also sends scalar words that pair a quiet NaN with a signalling NaN. It checks each lane field and the single flag against hand-derived values. Upper-lane signalling NaNs in a scalar half word are also sent, to confirm that unused lanes stay silent.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [2:0] {
    SEL_VH  = 3'd0,
    SEL_VS  = 3'd1,
    SEL_SH  = 3'd2,
    SEL_SS  = 3'd3,
    SEL_SD  = 3'd4,
    SEL_UND = 3'd5
  } sel_e;

  localparam int unsigned H_W = 16;
  localparam int unsigned H_E = 5;
  localparam int unsigned S_W = 32;
  localparam int unsigned S_E = 8;
  localparam int unsigned D_W = 64;
  localparam int unsigned D_E = 11;
endpackage

// File: rtl/fpmm_decode.sv
module fpmm_decode
  import fpmm_pkg::*;
(
  input  logic       vec_i,
  input  logic [1:0] size_i,
  output sel_e       sel_o
);
  always_comb begin
    sel_o = SEL_UND;
    if (vec_i) begin
      unique case (size_i)
        2'b00:   sel_o = SEL_VS;
        2'b01:   sel_o = SEL_VH;
        default: sel_o = SEL_UND;
      endcase
    end else begin
      unique case (size_i)
        2'b01:   sel_o = SEL_SH;
        2'b10:   sel_o = SEL_SS;
        2'b11:   sel_o = SEL_SD;
        default: sel_o = SEL_UND;
      endcase
    end
  end
endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         op_min_i,
  input  logic         vec_i,
  output logic [W-1:0] res_o,
  output logic         inv_o
);
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] QBIT = {{(EXP_W+1){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] a_f, b_f;
  logic a_nan, b_nan, a_snan, b_snan, a_lt;

  function automatic logic [W-1:0] flush(input logic [W-1:0] x, input logic en);
    if (en && (x[W-2:MAN_W] == '0) && (x[MAN_W-1:0] != '0))
      return {x[W-1], {(W-1){1'b0}}};
    return x;
  endfunction

  always_comb begin
    a_f    = flush(a_i, vec_i);
    b_f    = flush(b_i, vec_i);
    a_nan  = (a_f[W-2:MAN_W] == '1) && (a_f[MAN_W-1:0] != '0);
    b_nan  = (b_f[W-2:MAN_W] == '1) && (b_f[MAN_W-1:0] != '0);
    a_snan = a_nan && !a_f[MAN_W-1];
    b_snan = b_nan && !b_f[MAN_W-1];
    // sign-magnitude order; -0 sorts below +0
    unique case ({a_f[W-1], b_f[W-1]})
      2'b10:   a_lt = 1'b1;
      2'b01:   a_lt = 1'b0;
      2'b00:   a_lt = a_f[W-2:0] < b_f[W-2:0];
      default: a_lt = a_f[W-2:0] > b_f[W-2:0];
    endcase
    inv_o = a_snan | b_snan;
    if (a_nan && b_nan)   res_o = DNAN;
    else if (a_snan)      res_o = vec_i ? DNAN : (a_f | QBIT);
    else if (b_snan)      res_o = vec_i ? DNAN : (b_f | QBIT);
    else if (a_nan)       res_o = b_f;
    else if (b_nan)       res_o = a_f;
    else if (op_min_i)    res_o = a_lt ? a_f : b_f;
    else                  res_o = a_lt ? b_f : a_f;
  end
endmodule

// File: rtl/fpmm_lane_array.sv
module fpmm_lane_array #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned EXP_W  = 8,
  localparam int unsigned NUM   = DATA_W / LANE_W,
  localparam int unsigned MAN_W = LANE_W - 1 - EXP_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              op_min_i,
  input  logic              vec_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NUM-1:0]    inv_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_lane
    fpmm_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .a_i      (a_i[g*LANE_W +: LANE_W]),
      .b_i      (b_i[g*LANE_W +: LANE_W]),
      .op_min_i (op_min_i),
      .vec_i    (vec_i),
      .res_o    (res_o[g*LANE_W +: LANE_W]),
      .inv_o    (inv_o[g])
    );
  end
endmodule

// File: rtl/simd_fp_minmax.sv
module simd_fp_minmax
  import fpmm_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              vec_i,
  input  logic [1:0]        size_i,
  input  logic              op_min_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              invalid_o,
  output logic              undef_o
);
  localparam int unsigned H_N = DATA_W / H_W;
  localparam int unsigned S_N = DATA_W / S_W;
  localparam int unsigned D_N = DATA_W / D_W;

  sel_e              sel;
  logic [DATA_W-1:0] h_res, s_res, d_res, res_d;
  logic [H_N-1:0]    h_inv;
  logic [S_N-1:0]    s_inv;
  logic [D_N-1:0]    d_inv;
  logic              inv_d, und_d;

  fpmm_decode u_dec (.vec_i(vec_i), .size_i(size_i), .sel_o(sel));

  fpmm_lane_array #(.DATA_W(DATA_W), .LANE_W(H_W), .EXP_W(H_E)) u_half (
    .a_i(a_i), .b_i(b_i), .op_min_i(op_min_i), .vec_i(vec_i),
    .res_o(h_res), .inv_o(h_inv));
  fpmm_lane_array #(.DATA_W(DATA_W), .LANE_W(S_W), .EXP_W(S_E)) u_single (
    .a_i(a_i), .b_i(b_i), .op_min_i(op_min_i), .vec_i(vec_i),
    .res_o(s_res), .inv_o(s_inv));
  fpmm_lane_array #(.DATA_W(DATA_W), .LANE_W(D_W), .EXP_W(D_E)) u_double (
    .a_i(a_i), .b_i(b_i), .op_min_i(op_min_i), .vec_i(vec_i),
    .res_o(d_res), .inv_o(d_inv));

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    und_d = 1'b0;
    unique case (sel)
      SEL_VH: begin res_d = h_res; inv_d = |h_inv; end
      SEL_VS: begin res_d = s_res; inv_d = |s_inv; end
      SEL_SH: begin res_d = {{(DATA_W-H_W){1'b0}}, h_res[H_W-1:0]}; inv_d = h_inv[0]; end
      SEL_SS: begin res_d = {{(DATA_W-S_W){1'b0}}, s_res[S_W-1:0]}; inv_d = s_inv[0]; end
      SEL_SD: begin res_d = d_res; inv_d = d_inv[0]; end
      default: und_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
      undef_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= res_d;
        invalid_o <= inv_d;
        undef_o   <= und_d;
      end
    end
  end

  a_r10_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(invalid_o)));
  a_r9_undef_scalar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vec_i && size_i == 2'b00) |=> (undef_o && res_o == '0 && !invalid_o));
  a_r9_undef_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vec_i && size_i[1]) |=> (undef_o && res_o == '0 && !invalid_o));
  a_r8_half_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vec_i && size_i == 2'b01) |=> (res_o[DATA_W-1:H_W] == '0 && !undef_o));
  a_r8_single_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vec_i && size_i == 2'b10) |=> (res_o[DATA_W-1:S_W] == '0 && !undef_o));
  a_r4_pick_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !vec_i && size_i == 2'b11 &&
     a_i[DATA_W-2 -: D_E] != '1 && b_i[DATA_W-2 -: D_E] != '1)
    |=> (!invalid_o && (res_o == $past(a_i) || res_o == $past(b_i))));
endmodule

// File: tb/simd_fp_minmax_bench.sv
`timescale 1ns/1ps
module simd_fp_minmax_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        vec = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        op_min = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        valid_q, inv_q, und_q;
  logic [63:0] res_q;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  simd_fp_minmax u_simd_fp_minmax (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .vec_i(vec), .size_i(size),
    .op_min_i(op_min), .a_i(a), .b_i(b), .valid_o(valid_q), .res_o(res_q),
    .invalid_o(inv_q), .undef_o(und_q));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one word, sample one cycle later
  task automatic run(input logic v, input logic [1:0] s, input logic mn,
                     input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    valid = 1'b1; vec = v; size = s; op_min = mn; a = x; b = y;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [63:0] r, input logic inv,
                            input logic und);
    chk({tag, " res"}, res_q, r);
    chk({tag, " invalid"}, {63'd0, inv_q}, {63'd0, inv});
    chk({tag, " undef"}, {63'd0, und_q}, {63'd0, und});
    chk({tag, " valid"}, {63'd0, valid_q}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R11 valid", {63'd0, valid_q}, 64'd0);
    chk("R11 res", res_q, 64'd0);
    chk("R11 flags", {62'd0, inv_q, und_q}, 64'd0);
  endtask

  task automatic t_order;
    run(0, 2'b11, 0, 64'h3FF0000000000000, 64'h4000000000000000);
    expect_out("R4 dmax", 64'h4000000000000000, 0, 0);
    run(0, 2'b11, 1, 64'hC008000000000000, 64'h3FF0000000000000);
    expect_out("R4 dmin neg", 64'hC008000000000000, 0, 0);
    run(0, 2'b10, 0, 64'h00000000BF800000, 64'h00000000C0000000);
    expect_out("R4 smax two neg", 64'h00000000BF800000, 0, 0);
  endtask

  task automatic t_zero;
    run(0, 2'b10, 1, 64'h0, 64'h80000000);
    expect_out("R5 min zeros", 64'h80000000, 0, 0);
    run(0, 2'b10, 0, 64'h80000000, 64'h0);
    expect_out("R5 max zeros", 64'h0, 0, 0);
  endtask

  task automatic t_qnan;
    run(0, 2'b10, 1, 64'h7FC00000, 64'h40000000);
    expect_out("R1 scalar qnan", 64'h40000000, 0, 0);
    run(1, 2'b01, 0, 64'h7E00_3C00_C000_0000, 64'h4000_7E00_BC00_8000);
    expect_out("R1 R6 vec half max", 64'h4000_3C00_BC00_0000, 0, 0);
  endtask

  task automatic t_snan;
    run(0, 2'b11, 1, 64'h7FF0000000000001, 64'h3FF0000000000000);
    expect_out("R2 scalar snan", 64'h7FF8000000000001, 1, 0);
    // lane1 signalling, lane0 numeric
    run(1, 2'b00, 1, 64'h7F800001_3F800000, 64'h40000000_C0000000);
    expect_out("R2 R6 vec single", 64'h7FC00000_C0000000, 1, 0);
    // quiet NaN lane next to signalling lane
    run(1, 2'b01, 1, 64'h7E00_7C01_3C00_4000, 64'h3C00_4000_7E00_3C00);
    expect_out("R1 R2 mixed lanes", 64'h3C00_7E00_3C00_3C00, 1, 0);
    // signalling NaNs only in unused lanes
    run(0, 2'b01, 0, 64'h7C01_7C01_7C01_3C00, 64'h7C01_0000_0000_4000);
    expect_out("R2 R8 unused lanes", 64'h0000_0000_0000_4000, 0, 0);
  endtask

  task automatic t_both_nan;
    run(0, 2'b10, 1, 64'h7FC00123, 64'h7FC00456);
    expect_out("R3 two qnan", 64'h7FC00000, 0, 0);
    run(0, 2'b01, 0, 64'h7E01, 64'h7C05);
    expect_out("R3 qnan snan", 64'h7E00, 1, 0);
  endtask

  task automatic t_denorm;
    run(1, 2'b00, 1, 64'h00000001_80000001, 64'h0);
    expect_out("R7 vec flush", 64'h00000000_80000000, 0, 0);
    run(0, 2'b10, 0, 64'h00000001, 64'h0);
    expect_out("R7 scalar keep", 64'h00000001, 0, 0);
  endtask

  task automatic t_undef;
    run(1, 2'b10, 0, 64'h3FF0000000000000, 64'h4000000000000000);
    expect_out("R6 R9 vec size2", 64'h0, 0, 1);
    run(0, 2'b00, 1, 64'h7FF0000000000001, 64'h7C01);
    expect_out("R9 scalar size0", 64'h0, 0, 1);
    run(0, 2'b11, 1, 64'h3FF0000000000000, 64'h4000000000000000);
    expect_out("R9 undef clears", 64'h3FF0000000000000, 0, 0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    valid = 1; vec = 1; size = 2'b01; op_min = 1;
    a = 64'h3C00_4000_C000_BC00; b = 64'h4000_3C00_BC00_C000;
    @(negedge clk);
    a = 64'h0000_8000_7E00_3C00; b = 64'h8000_0000_3C00_7E00;
    expect_out("R10 word1", 64'h3C00_3C00_C000_C000, 0, 0);
    @(negedge clk);
    valid = 0; a = 64'h7C01_7C01_7C01_7C01;
    expect_out("R10 word2", 64'h8000_8000_3C00_3C00, 0, 0);
    @(negedge clk);
    chk("R10 hold res", res_q, 64'h8000_8000_3C00_3C00);
    chk("R10 valid low", {63'd0, valid_q}, 64'd0);
    chk("R10 hold flag", {63'd0, inv_q}, 64'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_order();
    t_zero();
    t_qnan();
    t_snan();
    t_both_nan();
    t_denorm();
    t_undef();
    t_stream();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule